// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block takes one 28-bit pixel word per pixel clock period and sends it out as four serial data lanes. Each lane carries seven bits per pixel period, so every lane runs at seven times the pixel rate. A fifth serial lane carries a forwarded clock at the pixel frequency, lined up with the data slots, so a receiver can recover the slot boundaries. The 28 bits are normally 24 colour bits (eight each of red, green and blue) and four control bits, such as line sync, frame sync and data enable. This block does not care which bit holds which signal.

A strobe-select input chooses which pixel-clock edge samples the input word. When it is high, the rising edge samples the word. When it is low, the falling edge samples it, and low is the default. An active-low power-down input turns off the output-enable flag of every serial lane, which models a tristated driver, and forces the lane values low. The bit clock comes from an outside source at seven times the pixel rate and is phase locked to the pixel clock. Every pixel-clock transition falls between two rising edges of the bit clock.

Top module: `px7_link_tx`

## Requirements
- R1: While `rst_n` is low at a rising bit-clock edge, all output-enable flags are low after that edge, and every lane value, clock lane included, is 0.
- R2: Each input word sampled at a capture edge appears in full on the four data lanes, spread over seven consecutive bit slots.
- R3: Data lane n in slot k (k = 0 for the first slot after the load) carries input bit 7n+k, with n = 0..3 and k = 0..6.
- R4: The clock lane carries 1,1,0,0,0,1,1 in slots 0 to 6 of every pixel period.
- R5: With `edge_sel` = 1, the word is sampled on the rising pixel-clock edge. A different value present at the falling edge has no effect on the lanes.
- R6: With `edge_sel` = 0, the word is sampled on the falling pixel-clock edge. A different value present at the rising edge has no effect on the lanes.
- R7: Slot 0 of a sampled word is driven from the first rising bit-clock edge after the capture edge. Consecutive words follow back to back, with no slot dropped or repeated.
- R8: When `pwr_n` is low at a rising bit-clock edge, every output-enable flag is low after that edge and all lane values read 0. Once `pwr_n` is high again, the flags return high one edge later and the stream carries on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate, phase locked to it |
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_sel | input | 1 | Capture-edge select: 1 rising, 0 falling |
| pwr_n | input | 1 | Active-low power-down; low disables all serial outputs |
| pix_word | input | 28 | Parallel pixel word |
| lane_dat | output | 4 | Serial data lanes |
| lane_oe | output | 4 | Output-enable flag for each data lane |
| lane_clk | output | 1 | Serial forwarded-clock lane |
| clk_oe | output | 1 | Output-enable flag for the clock lane |

## Verification
A word sampled at a capture edge shows slot 0 on the lanes one bit-clock rising edge later, which is the first rising edge after that pixel transition. Slots 1 to 6 follow on the next six edges. A power-down change reaches the enable flags one bit-clock edge after it is sampled. The bench keeps its own pixel-phase counter. From that counter alone, and from the selected edge, it works out which slot is on the lanes, and it samples 1 ns after each rising bit-clock edge. The scoreboard pushes a word only at the edge that captures it. Between the two edges, the bench drives the inverse of the word as a decoy, so a capture on the wrong edge shows up as a mismatch.

// File: rtl/px7_pkg.sv
// Shared constants and types for the seven-to-one link serializer.
// Assumes the bit clock is seven times the pixel clock.
package px7_pkg;

    localparam int LANES_DEF = 4;
    localparam int SLOTS_DEF = 7;

    // Forwarded clock pattern, bit k is the value in slot k.
    localparam logic [SLOTS_DEF-1:0] CLK_PAT_DEF = 7'b1100011;

    typedef enum logic {
        STROBE_FALL = 1'b0,
        STROBE_RISE = 1'b1
    } strobe_e;

endpackage

// File: rtl/px7_capture.sv
// Samples the parallel word on both pixel-clock edges and hands the copy
// taken on the selected edge to the bit-clock domain.
// Assumes the word is stable around the selected edge only.
module px7_capture #(
    parameter int WORD_W = 28
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] pix_word,
    output logic [WORD_W-1:0] cap_word
);
    import px7_pkg::*;

    logic [WORD_W-1:0] rise_q;
    logic [WORD_W-1:0] fall_q;

    // Sample on the rising pixel edge.
    always_ff @(posedge pix_clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= pix_word;
    end

    // Sample on the falling pixel edge.
    always_ff @(negedge pix_clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= pix_word;
    end

    // Pick the copy taken on the programmed strobe edge.
    always_comb begin
        if (strobe_e'(edge_sel) == STROBE_RISE) cap_word = rise_q;
        else                                    cap_word = fall_q;
    end

endmodule

// File: rtl/px7_align.sv
// Finds the selected pixel-clock edge in the bit-clock domain and gives a
// one-cycle load strobe at the first bit-clock rising edge after it.
// Assumes pixel-clock transitions fall between bit-clock rising edges.
module px7_align (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic edge_sel,
    output logic load
);
    import px7_pkg::*;

    logic pclk_q;

    // Remember the pixel-clock level seen at the last bit-clock edge.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) pclk_q <= 1'b0;
        else        pclk_q <= pix_clk;
    end

    // Flag the first bit slot that follows the selected transition.
    always_comb begin
        if (strobe_e'(edge_sel) == STROBE_RISE) load = rst_n & pix_clk & ~pclk_q;
        else                                    load = rst_n & ~pix_clk & pclk_q;
    end

endmodule

// File: rtl/px7_lane_shift.sv
// One serial lane: loads a slot-ordered vector on load and shifts it
// out least significant bit first, one slot per bit clock.
// Assumes loads come every SLOTS cycles.
module px7_lane_shift #(
    parameter int SLOTS = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] par_in,
    output logic             ser_out
);
    logic [SLOTS-1:0] sh;

    // Load a new vector or move to the next slot.
    always_ff @(posedge bit_clk) begin
        if (!rst_n)    sh <= '0;
        else if (load) sh <= par_in;
        else           sh <= {1'b0, sh[SLOTS-1:1]};
    end

    // Present the current slot.
    always_comb ser_out = sh[0];

endmodule

// File: rtl/px7_link_tx.sv
// Seven-to-one display link serializer top. It captures one word per pixel
// clock, serializes it onto LANES data lanes plus a forwarded clock lane,
// and gates all lanes with a power-down enable.
// Assumes bit_clk = SLOTS x pix_clk, phase locked.
module px7_link_tx #(
    parameter int                LANES   = px7_pkg::LANES_DEF,
    parameter int                SLOTS   = px7_pkg::SLOTS_DEF,
    parameter logic [SLOTS-1:0]  CLK_PAT = px7_pkg::CLK_PAT_DEF
) (
    input  logic                   bit_clk,
    input  logic                   pix_clk,
    input  logic                   rst_n,
    input  logic                   edge_sel,
    input  logic                   pwr_n,
    input  logic [LANES*SLOTS-1:0] pix_word,
    output logic [LANES-1:0]       lane_dat,
    output logic [LANES-1:0]       lane_oe,
    output logic                   lane_clk,
    output logic                   clk_oe
);
    localparam int WORD_W = LANES * SLOTS;

    logic [WORD_W-1:0] cap_word;
    logic              load;
    logic [LANES-1:0]  ser_dat;
    logic              ser_clk;
    logic              oe_q;

    px7_capture #(.WORD_W(WORD_W)) u_cap (
        .pix_clk  (pix_clk),
        .rst_n    (rst_n),
        .edge_sel (edge_sel),
        .pix_word (pix_word),
        .cap_word (cap_word)
    );

    px7_align u_align (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .pix_clk  (pix_clk),
        .edge_sel (edge_sel),
        .load     (load)
    );

    // One shifter per data lane; lane n takes bits 7n..7n+6.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        px7_lane_shift #(.SLOTS(SLOTS)) u_sh (
            .bit_clk (bit_clk),
            .rst_n   (rst_n),
            .load    (load),
            .par_in  (cap_word[n*SLOTS +: SLOTS]),
            .ser_out (ser_dat[n])
        );
    end

    px7_lane_shift #(.SLOTS(SLOTS)) u_clk_sh (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .load    (load),
        .par_in  (CLK_PAT),
        .ser_out (ser_clk)
    );

    // Register the power-down state as the common output enable.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= pwr_n;
    end

    // Gate lane values and drive the enable flags.
    always_comb begin
        lane_dat = ser_dat & {LANES{oe_q}};
        lane_clk = ser_clk & oe_q;
        lane_oe  = {LANES{oe_q}};
        clk_oe   = oe_q;
    end

endmodule

// File: rtl/px7_link_tx_chk.sv
// Assertion checker for px7_link_tx, bound to every instance.
module px7_link_tx_chk #(
    parameter int LANES  = 4,
    parameter int WORD_W = 28
) (
    input logic              bit_clk,
    input logic              rst_n,
    input logic              pwr_n,
    input logic              load,
    input logic [WORD_W-1:0] cap_word,
    input logic [LANES-1:0]  lane_dat,
    input logic [LANES-1:0]  lane_oe,
    input logic              lane_clk,
    input logic              clk_oe
);
    a_r1_reset_off: assert property (@(posedge bit_clk)
        !rst_n |=> (lane_oe == '0 && !clk_oe));

    a_r8_pwr_off: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pwr_n |=> (lane_oe == '0 && !clk_oe));

    a_r8_pwr_on: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pwr_n |=> (lane_oe == '1 && clk_oe));

    a_r8_off_quiet: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !clk_oe |-> (lane_dat == '0 && !lane_clk));

    a_r4_clk_slot0: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> (!clk_oe || lane_clk));

    a_r3_lane0_slot0: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> (!lane_oe[0] || lane_dat[0] == $past(cap_word[0])));

    a_r7_load_spacing: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> !load);

endmodule

bind px7_link_tx px7_link_tx_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .pwr_n    (pwr_n),
    .load     (load),
    .cap_word (cap_word),
    .lane_dat (lane_dat),
    .lane_oe  (lane_oe),
    .lane_clk (lane_clk),
    .clk_oe   (clk_oe)
);

// File: tb/test_px7_link_tx.sv
module test_px7_link_tx;

    logic        bit_clk = 1'b0;
    logic        pix_clk;
    logic        rst_n = 1'b0;
    logic        edge_sel = 1'b0;
    logic        pwr_n = 1'b1;
    logic [27:0] pix_word = '0;
    logic [3:0]  lane_dat;
    logic [3:0]  lane_oe;
    logic        lane_clk;
    logic        clk_oe;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    int rx_cnt = 0;
    bit mon_on = 0;
    bit done = 0;
    logic [27:0] exp_q[$];

    px7_link_tx i_px7_link_tx (
        .bit_clk, .pix_clk, .rst_n, .edge_sel, .pwr_n, .pix_word,
        .lane_dat, .lane_oe, .lane_clk, .clk_oe
    );

    always #2 bit_clk = ~bit_clk;

    // Pixel phase: pixel clock is high for phases 0..3, low for 4..6.
    always @(negedge bit_clk) ph <= (ph == 6) ? 0 : ph + 1;
    assign pix_clk = (ph < 4);

    function automatic int base_ph();
        return edge_sel ? 0 : 4;
    endfunction

    function automatic int opp_ph();
        return edge_sel ? 4 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_ph(input int target);
        do begin
            @(negedge bit_clk);
            #1;
        end while (ph != target);
    endtask

    logic [27:0] prev_w;
    bit          have_prev = 0;

    // Driver: pushes the word captured at this edge, then decoy, then next word.
    task automatic drive_word(input logic [27:0] w);
        wait_ph(base_ph());
        if (have_prev) exp_q.push_back(prev_w);
        pix_word = ~w;
        wait_ph(opp_ph());
        pix_word = w;
        prev_w = w;
        have_prev = 1;
    endtask

    task automatic flush();
        wait_ph(base_ph());
        if (have_prev) exp_q.push_back(prev_w);
        have_prev = 0;
        repeat (10) @(posedge bit_clk);
    endtask

    function automatic logic [27:0] word_at(input int i);
        logic [31:0] h;
        if (i == 0) return 28'h0000000;
        if (i == 1) return 28'hFFFFFFF;
        if (i < 8)  return 28'h1 << ((i * 5) % 28);
        if (i == 8) return 28'hAAAAAAA;
        if (i == 9) return 28'h5555555;
        h = i * 32'h9E3779B1;
        return h[27:0];
    endfunction

    // Monitor: assembles seven slots, compares to the scoreboard head.
    bit          collecting = 0;
    logic [27:0] got;
    logic [27:0] expw;
    logic [6:0]  clkbits;
    always begin
        @(posedge bit_clk);
        #1;
        if (!mon_on) collecting = 0;
        else begin
            int s;
            s = (ph - base_ph() + 7) % 7;
            if (s == 0 && exp_q.size() > 0) begin
                expw = exp_q.pop_front();
                collecting = 1;
            end
            if (collecting) begin
                for (int n = 0; n < 4; n++) got[7*n + s] = lane_dat[n];
                clkbits[s] = lane_clk;
                if (s == 6) begin
                    chk(got == expw, edge_sel ? "R2 R3 R5 R7 word" : "R2 R3 R6 R7 word",
                        {4'h0, got}, {4'h0, expw});
                    chk(clkbits == 7'b1100011, "R4 clock lane", {25'h0, clkbits},
                        32'h63);
                    chk(lane_oe == 4'hF && clk_oe, "R8 enabled while streaming",
                        {27'h0, clk_oe, lane_oe}, 32'h1F);
                    rx_cnt++;
                    collecting = 0;
                end
            end
        end
    end

    task automatic run_batch(input int first, input int count);
        rx_cnt = 0;
        mon_on = 1;
        for (int i = 0; i < count; i++) drive_word(word_at(first + i));
        flush();
        chk(rx_cnt == count, "R7 words received", rx_cnt, count);
        chk(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);
        mon_on = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (10) @(posedge bit_clk);
        #1;
        chk(lane_oe == 4'h0 && !clk_oe, "R1 reset enables", {27'h0, clk_oe, lane_oe}, 0);
        chk(lane_dat == 4'h0 && !lane_clk, "R1 reset lanes", {27'h0, lane_clk, lane_dat}, 0);
        rst_n = 1'b1;
        repeat (21) @(posedge bit_clk);

        // Falling-edge capture (default).
        run_batch(0, 16);

        // Power-down: enables drop one edge later, lanes stay quiet.
        @(posedge bit_clk);
        #1;
        pwr_n = 1'b0;
        @(posedge bit_clk);
        #1;
        chk(lane_oe == 4'h0 && !clk_oe, "R8 power-down enables", {27'h0, clk_oe, lane_oe}, 0);
        for (int c = 0; c < 8; c++) begin
            @(posedge bit_clk);
            #1;
            chk(lane_dat == 4'h0 && !lane_clk, "R8 power-down lanes",
                {27'h0, lane_clk, lane_dat}, 0);
        end
        pwr_n = 1'b1;
        @(posedge bit_clk);
        #1;
        chk(lane_oe == 4'hF && clk_oe, "R8 power-up enables", {27'h0, clk_oe, lane_oe}, 32'h1F);
        run_batch(16, 6);

        // Rising-edge capture.
        edge_sel = 1'b1;
        repeat (21) @(posedge bit_clk);
        run_batch(0, 16);

        // Back to falling to confirm the switch holds both ways.
        edge_sel = 1'b0;
        repeat (21) @(posedge bit_clk);
        run_batch(3, 8);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule